// File: doc/BRIEF.md
# Bank-Switching Memory Decoder with Colour Configuration Port

This block sits between an 8-bit CPU with a 16-bit address bus and the memories of a small home-computer board. On each memory cycle it raises one chip select for the boot ROM, the keyboard matrix window, the system RAM or a 1 KB colour attribute RAM. It tracks bus cycles with a small state machine and keeps a one-byte configuration register behind a fixed I/O port. Two bits of that register rework the memory map while the machine runs. A third bit goes to the video output and selects colour attributes or plain white-on-black.

The ROM-extension bit comes up set. While it is set, the highest 256-byte copy of the keyboard window is given to ROM, which holds a start-up routine. Software later clears the bit to get back all four keyboard copies. The attribute-bank bit swaps the colour RAM in over the top kilobyte of system RAM. It is a true exchange, so exactly one of the two answers there. Reading the port returns the eight DIP-switch inputs instead of the stored bits, which lets the start-up routine fetch a default colour byte.

Memory map (addresses in hex): ROM 0000-37FF, keyboard 3800-3BFF (four 256-byte copies), unmapped 3C00-3FFF, system RAM 4000-FFFF, with the attribute RAM able to take FC00-FFFF. The configuration port is the one whose low address byte is C4.

Bus-cycle states: `ST_IDLE` (no request), `ST_MEM` (memory cycle), `ST_CFG_RD` (port read), `ST_CFG_WR` (port write). The next state follows the current request in every state. The transition out of `ST_CFG_WR` to any other state commits the captured byte. Staying in `ST_CFG_WR` keeps capturing the data bus.

Top module: `bank_map_decoder`

## Requirements
- R1: After reset the ROM-extension bit (bit 0) is 1, and the attribute-bank bit (bit 1) and the colour-display bit (bit 2) are 0.
- R2: With the extension bit clear, a memory read of 0000-37FF selects only ROM, any access to 3800-3BFF selects only the keyboard, and any access to 4000-FFFF selects only system RAM while the attribute bank is off.
- R3: With the extension bit set, a read of 3B00-3BFF selects ROM, and the other three keyboard copies 3800-3AFF still select the keyboard.
- R4: With bit 1 set, accesses to FC00-FFFF select only the attribute RAM and never system RAM. With bit 1 clear, the attribute RAM is never selected.
- R5: An I/O write to the port (low address byte C4) is captured on each clock edge where it is present. It is committed on the first edge where it is no longer present. Only bits 2:0 are stored, and bits 7:3 read as 0.
- R6: An I/O read of the port drives the DIP-switch value with the read-drive flag high. I/O reads of other ports leave the flag low.
- R7: At most one chip select is high at any time. None is high during I/O cycles or when no memory request carries a read or write strobe.
- R8: A memory write that decodes to ROM, including the extension window, raises no chip select.
- R9: A memory read of 3C00-3FFF raises no chip select and drives FF with the read-drive flag high. A write there selects nothing.
- R10: The colour-display output equals register bit 2.
- R11: A memory cycle in the cycle just after a port write still decodes with the old map. The new map applies from the cycle after the commit edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | CPU address bus |
| mem_req | input | 1 | Memory request, active high |
| io_req | input | 1 | I/O request, active high |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| wdata | input | 8 | CPU write data |
| dip_sw | input | 8 | DIP-switch levels returned by a port read |
| sel_rom | output | 1 | ROM chip select |
| sel_kbd | output | 1 | Keyboard window select |
| sel_sysram | output | 1 | System RAM select |
| sel_attr | output | 1 | Colour attribute RAM select |
| rdata | output | 8 | Data driven by the decoder itself |
| rdata_oe | output | 1 | Decoder drives rdata this cycle |
| color_show | output | 1 | Video uses attributes (1) or white-on-black (0) |

## Verification
The hardest case to reach from the ports is the one-cycle gap between a port write and the moment its new map takes effect. A memory access issued in the very next cycle must still see the old decode, and only the access after that sees the new one. The stimulus produces this by running port writes straight into reads of 3B00-3BFF and FC00-FFFF, once with a single-cycle write and once with a write held over several cycles. The behavioural model in the bench commits on the edge where the write drops and compares every select on every cycle.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    localparam int CFG_W = 3;

    typedef struct packed {
        logic color_show;
        logic attr_bank;
        logic rom_ext;
    } cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MEM    = 2'd1,
        ST_CFG_RD = 2'd2,
        ST_CFG_WR = 2'd3
    } cyc_state_t;

    localparam cfg_t CFG_RESET = '{color_show: 1'b0, attr_bank: 1'b0, rom_ext: 1'b1};

endpackage

// File: rtl/bus_cycle_fsm.sv
module bus_cycle_fsm
    import bank_map_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mem_cyc,
    input  logic port_rd,
    input  logic port_wr,
    output logic capture,
    output logic commit
);

    cyc_state_t state, next_state;

    always_comb begin
        next_state = ST_IDLE;
        unique case (state)
            ST_IDLE, ST_MEM, ST_CFG_RD, ST_CFG_WR: begin
                if (port_wr)      next_state = ST_CFG_WR;
                else if (port_rd) next_state = ST_CFG_RD;
                else if (mem_cyc) next_state = ST_MEM;
                else              next_state = ST_IDLE;
            end
            default: next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    always_comb begin
        capture = (next_state == ST_CFG_WR);
        commit  = (state == ST_CFG_WR) && (next_state != ST_CFG_WR);
    end

endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import bank_map_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              commit,
    input  logic [DATA_W-1:0] din,
    output cfg_t              cfg
);

    cfg_t pending;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= CFG_RESET;
            cfg     <= CFG_RESET;
        end else begin
            if (commit)  cfg     <= pending;
            if (capture) pending <= cfg_t'(din[CFG_W-1:0]);
        end
    end

endmodule

// File: rtl/addr_decode.sv
module addr_decode
    import bank_map_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int ROM_BYTES  = 14336,
    parameter int KBD_BYTES  = 1024,
    parameter int KBD_COPY   = 256,
    parameter int RAM_BASE   = 16384,
    parameter int ATTR_BYTES = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_cyc,
    input  logic              is_wr,
    input  cfg_t              cfg,
    output logic              sel_rom,
    output logic              sel_kbd,
    output logic              sel_sysram,
    output logic              sel_attr,
    output logic              hole_rd
);

    localparam logic [ADDR_W:0] KBD_LO   = (ADDR_W+1)'(ROM_BYTES);
    localparam logic [ADDR_W:0] KBD_HI   = (ADDR_W+1)'(ROM_BYTES + KBD_BYTES);
    localparam logic [ADDR_W:0] EXT_LO   = (ADDR_W+1)'(ROM_BYTES + KBD_BYTES - KBD_COPY);
    localparam logic [ADDR_W:0] RAM_LO   = (ADDR_W+1)'(RAM_BASE);
    localparam logic [ADDR_W:0] ATTR_LO  = (ADDR_W+1)'((1 << ADDR_W) - ATTR_BYTES);

    logic [ADDR_W:0] a;
    logic in_rom, in_kbd, in_ext, in_ram, in_attr, in_hole;

    always_comb begin
        a       = {1'b0, addr};
        in_rom  = a < KBD_LO;
        in_kbd  = (a >= KBD_LO) && (a < KBD_HI);
        in_ext  = in_kbd && (a >= EXT_LO) && cfg.rom_ext;
        in_ram  = a >= RAM_LO;
        in_attr = (a >= ATTR_LO) && cfg.attr_bank;
        in_hole = (a >= KBD_HI) && (a < RAM_LO);

        sel_rom    = mem_cyc && !is_wr && (in_rom || in_ext);
        sel_kbd    = mem_cyc && in_kbd && !in_ext;
        sel_attr   = mem_cyc && in_attr;
        sel_sysram = mem_cyc && in_ram && !in_attr;
        hole_rd    = mem_cyc && !is_wr && in_hole;
    end

endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
    import bank_map_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          DATA_W     = 8,
    parameter int          ROM_BYTES  = 14336,
    parameter int          KBD_BYTES  = 1024,
    parameter int          KBD_COPY   = 256,
    parameter int          RAM_BASE   = 16384,
    parameter int          ATTR_BYTES = 1024,
    parameter logic [7:0]  CFG_PORT   = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mem_req,
    input  logic              io_req,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] dip_sw,
    output logic              sel_rom,
    output logic              sel_kbd,
    output logic              sel_sysram,
    output logic              sel_attr,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              color_show
);

    logic mem_cyc, is_wr, port_hit, port_rd, port_wr;
    logic capture, commit, hole_rd;
    cfg_t cfg;

    always_comb begin
        is_wr    = wr_en;
        mem_cyc  = mem_req && !io_req && (rd_en || wr_en);
        port_hit = io_req && !mem_req && (addr[7:0] == CFG_PORT);
        port_rd  = port_hit && rd_en && !wr_en;
        port_wr  = port_hit && wr_en;
    end

    bus_cycle_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_cyc (mem_cyc),
        .port_rd (port_rd),
        .port_wr (port_wr),
        .capture (capture),
        .commit  (commit)
    );

    cfg_store #(.DATA_W(DATA_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .commit  (commit),
        .din     (wdata),
        .cfg     (cfg)
    );

    addr_decode #(
        .ADDR_W     (ADDR_W),
        .ROM_BYTES  (ROM_BYTES),
        .KBD_BYTES  (KBD_BYTES),
        .KBD_COPY   (KBD_COPY),
        .RAM_BASE   (RAM_BASE),
        .ATTR_BYTES (ATTR_BYTES)
    ) u_dec (
        .addr       (addr),
        .mem_cyc    (mem_cyc),
        .is_wr      (is_wr),
        .cfg        (cfg),
        .sel_rom    (sel_rom),
        .sel_kbd    (sel_kbd),
        .sel_sysram (sel_sysram),
        .sel_attr   (sel_attr),
        .hole_rd    (hole_rd)
    );

    always_comb begin
        rdata_oe   = port_rd || hole_rd;
        rdata      = port_rd ? dip_sw : {DATA_W{1'b1}};
        color_show = cfg.color_show;
    end

endmodule

// File: rtl/bank_map_checker.sv
module bank_map_checker #(
    parameter int         ADDR_W   = 16,
    parameter int         DATA_W   = 8,
    parameter logic [7:0] CFG_PORT = 8'hC4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              mem_req,
    input logic              io_req,
    input logic              rd_en,
    input logic              wr_en,
    input logic [DATA_W-1:0] dip_sw,
    input logic              sel_rom,
    input logic              sel_kbd,
    input logic              sel_sysram,
    input logic              sel_attr,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              color_show
);

    logic port_w;
    assign port_w = io_req && !mem_req && wr_en && (addr[7:0] == CFG_PORT);

    // R7: never two selects at once
    p_one_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_rom, sel_kbd, sel_sysram, sel_attr}));

    // R7: I/O cycles leave memory alone
    p_io_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !mem_req) |-> !(sel_rom || sel_kbd || sel_sysram || sel_attr));

    // R8: writes to ROM space drive no select
    p_rom_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !io_req && wr_en && addr < 16'h3800) |-> !(sel_rom || sel_kbd || sel_sysram || sel_attr));

    // R4: attribute RAM only in the top kilobyte
    p_attr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_attr |-> (addr[15:10] == 6'h3F));

    // R9: hole reads return all ones
    p_hole_ff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !io_req && rd_en && !wr_en && addr[15:10] == 6'h0F) |-> (rdata_oe && rdata == 8'hFF));

    // R6: port read returns switches
    p_dip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && !mem_req && rd_en && !wr_en && addr[7:0] == CFG_PORT) |-> (rdata_oe && rdata == dip_sw));

    // R5: configuration output only moves after a port write
    p_cfg_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(color_show) |-> $past(port_w, 2));

endmodule

bind bank_map_decoder bank_map_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_PORT(CFG_PORT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .io_req(io_req),
    .rd_en(rd_en), .wr_en(wr_en), .dip_sw(dip_sw), .sel_rom(sel_rom),
    .sel_kbd(sel_kbd), .sel_sysram(sel_sysram), .sel_attr(sel_attr),
    .rdata(rdata), .rdata_oe(rdata_oe), .color_show(color_show)
);

// File: tb/bank_map_decoder_test.sv
module bank_map_decoder_test;

    localparam int PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] addr = 0;
    logic        mem_req = 0, io_req = 0, rd_en = 0, wr_en = 0;
    logic [7:0]  wdata = 0, dip_sw = 8'h5A;
    logic        sel_rom, sel_kbd, sel_sysram, sel_attr, rdata_oe, color_show;
    logic [7:0]  rdata;

    int tests = 0, fails = 0;
    bit done = 0;

    // behavioural model state
    int m_cfg = 1, m_pend = 0;
    bit m_inwr = 0;

    bank_map_decoder uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req), .io_req(io_req),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .dip_sw(dip_sw),
        .sel_rom(sel_rom), .sel_kbd(sel_kbd), .sel_sysram(sel_sysram),
        .sel_attr(sel_attr), .rdata(rdata), .rdata_oe(rdata_oe), .color_show(color_show)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cfg = 1; m_pend = 0; m_inwr = 0;
        end else begin
            bit wnow;
            wnow = io_req && !mem_req && wr_en && (addr[7:0] == 8'hC4);
            if (m_inwr && !wnow) m_cfg = m_pend;
            if (wnow) m_pend = wdata & 7;
            m_inwr = wnow;
        end
    end

    task automatic expect_now(input string tag);
        int a;
        bit mem, wr, rom, kbd, ram, attr, oe;
        bit [7:0] d;
        a = addr; wr = wr_en;
        mem = mem_req && !io_req && (rd_en || wr_en);
        rom = 0; kbd = 0; ram = 0; attr = 0; oe = 0; d = 8'hFF;
        if (mem) begin
            if (a < 'h3800) rom = !wr;
            else if (a < 'h3C00) begin
                if (a >= 'h3B00 && (m_cfg & 1)) rom = !wr; else kbd = 1;
            end else if (a < 'h4000) oe = !wr;
            else if (a >= 'hFC00 && (m_cfg & 2)) attr = 1;
            else ram = 1;
        end
        if (io_req && !mem_req && rd_en && !wr_en && addr[7:0] == 8'hC4) begin
            oe = 1; d = dip_sw;
        end
        tests++;
        if ({sel_rom, sel_kbd, sel_sysram, sel_attr} != {rom, kbd, ram, attr}) begin
            fails++;
            $display("FAIL %s addr=%h sel=%b expected %b", tag, addr,
                     {sel_rom, sel_kbd, sel_sysram, sel_attr}, {rom, kbd, ram, attr});
        end
        tests++;
        if (rdata_oe !== oe || (oe && rdata !== d)) begin
            fails++;
            $display("FAIL %s addr=%h oe=%b data=%h expected oe=%b data=%h", tag, addr,
                     rdata_oe, rdata, oe, d);
        end
        tests++;
        if (color_show !== ((m_cfg >> 2) & 1)) begin
            fails++;
            $display("FAIL R10 %s color_show=%b expected %0d", tag, color_show, (m_cfg >> 2) & 1);
        end
    endtask

    task automatic cyc(input bit m, input bit io, input bit r, input bit w,
                       input logic [15:0] a, input logic [7:0] d, input string tag);
        @(posedge clk); #1;
        mem_req = m; io_req = io; rd_en = r; wr_en = w; addr = a; wdata = d;
        @(negedge clk);
        expect_now(tag);
    endtask

    task automatic mrd(input logic [15:0] a, input string tag); cyc(1,0,1,0,a,0,tag); endtask
    task automatic mwr(input logic [15:0] a, input string tag); cyc(1,0,0,1,a,8'h33,tag); endtask
    task automatic pwr(input logic [7:0] d, input string tag); cyc(0,1,0,1,16'h00C4,d,tag); endtask
    task automatic idle(input string tag); cyc(0,0,0,0,16'h0000,0,tag); endtask

    initial begin
        #(PERIOD*3);
        @(negedge clk);
        tests++;
        if (color_show !== 1'b0) begin
            fails++; $display("FAIL R1 color_show=%b expected 0", color_show);
        end
        rst_n = 1;
        // R1: extension window belongs to ROM after reset
        mrd(16'h3B40, "R1"); mrd(16'hFC10, "R1"); idle("R7");
        // R2 / R3 base map with extension on
        mrd(16'h0000, "R2"); mrd(16'h37FF, "R2"); mrd(16'h3800, "R3");
        mrd(16'h3AFF, "R3"); mrd(16'h3BFF, "R3"); mrd(16'h4000, "R2"); mwr(16'hFFFF, "R2");
        // R8: ROM writes select nothing, including extension window
        mwr(16'h0100, "R8"); mwr(16'h3B00, "R8");
        // R9: hole
        mrd(16'h3C00, "R9"); mrd(16'h3FFF, "R9"); mwr(16'h3D00, "R9");
        // R6: port reads
        cyc(0,1,1,0,16'h00C4,0,"R6"); dip_sw = 8'hA3; cyc(0,1,1,0,16'h12C4,0,"R6");
        cyc(0,1,1,0,16'h00C5,0,"R6");
        // R7: request without strobe, both requests, I/O write elsewhere
        cyc(1,0,0,0,16'h5000,0,"R7"); cyc(0,1,0,1,16'h0010,8'hFF,"R7");
        // R5/R11: single-cycle write then immediate accesses
        pwr(8'hFE, "R5"); mrd(16'h3B00, "R11"); mrd(16'h3B00, "R3");
        mrd(16'hFC00, "R4"); mwr(16'hFFFF, "R4"); mrd(16'hFBFF, "R4");
        // held write: last byte wins, commit on drop
        pwr(8'h01, "R5"); pwr(8'h01, "R5"); pwr(8'h03, "R5");
        mrd(16'hFC00, "R11"); mrd(16'hFC00, "R4"); mrd(16'h3B80, "R3");
        // clear everything; reserved bits ignored
        pwr(8'hF8, "R5"); idle("R5"); mrd(16'hFC00, "R4"); mrd(16'h3B00, "R2");
        mrd(16'h3A00, "R2"); mwr(16'h3BFF, "R2");
        // write with mem cycle between strobes
        pwr(8'h04, "R10"); mwr(16'hFD00, "R11"); mrd(16'hFD00, "R4");
        for (int i = 0; i < 64; i++) begin
            cyc(i[0], i[1] & ~i[0], 1, i[2], {i[5:0], 10'h2A5}, 8'(i), "R7");
        end
        idle("R7");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(PERIOD*20000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule